// File: doc/BRIEF.md
# Windowed Bit-Error Count Monitor

The block estimates the raw channel bit error rate of a receiver. Each cycle it may receive a pair of already-aligned bits under a valid strobe: the received hard decision and the same bit rebuilt by re-encoding the decoder output. A mismatch marks one error. Errors are summed over a window whose length is a programmable number of data bits. When the window closes, the total moves into a result register and an interrupt is raised. The result keeps its value until the next window closes.

A second, independent path supports dish pointing. When it is enabled, a running error counter toggles a status pin each time it reaches a programmable threshold, and then starts again from zero. The toggle rate therefore follows the error rate and can drive an audible or visual indicator.

Software reaches the block through a small synchronous write port with three registers. Address 0 holds the window period, address 1 the coarse threshold, and address 2 the control bits. An acknowledge strobe stands for the read of the interrupt register.

Top module: `bit_err_monitor`

## Requirements
- R1: A valid pair (`bit_valid_i`=1) counts one error when `rx_bit_i` differs from `ref_bit_i`. Pairs with `bit_valid_i`=0 are ignored by both the window count and the coarse count.
- R2: A window spans `P * 2^WIN_SHIFT` valid bits, where P is the period register at address 0. `WIN_SHIFT` defaults to 18. `err_total_o` does not change before the last bit of the window.
- R3: While the period register is 0, no window completes: `err_total_o` stays unchanged and no interrupt is raised.
- R4: On the clock edge that takes the last valid bit of a window, `err_total_o` is loaded with the error count of that window, including that last bit. The accumulator then restarts from zero.
- R5: `err_total_o` holds its value between window ends. An interrupt acknowledge does not clear it.
- R6: The error count saturates at all ones (2^CNT_W - 1) and never wraps.
- R7: When control bit 0 (interrupt enable) is set, a window end drives `irq_no` low from the next cycle on. `irq_no` stays low until it is acknowledged. With the enable clear, `irq_no` stays high.
- R8: A pulse on `irq_ack_i` returns `irq_no` high in the next cycle. If a new enabled window end occurs in the same cycle, the line stays low.
- R9: When control bit 1 (coarse enable) is set, `status_o` toggles on the valid error that brings the running count up to the threshold at address 1. That count then restarts from zero. A threshold of 0 never toggles. Writing the threshold, or clearing the enable, zeroes the running count, and `status_o` holds its level.
- R10: A write to the period register restarts the window and clears the accumulator. A bit pair offered in the same cycle is not counted for the window.
- R11: After reset, `err_total_o`=0, `irq_no`=1, `status_o`=0, and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | Bit pair strobe |
| rx_bit_i | input | 1 | Delayed received hard-decision bit |
| ref_bit_i | input | 1 | Re-encoded decoded bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 period, 1 threshold, 2 control |
| wr_data_i | input | REG_W | Register write data |
| irq_ack_i | input | 1 | Interrupt register read, releases the interrupt |
| err_total_o | output | CNT_W | Error total of the last completed window |
| irq_no | output | 1 | Interrupt, active low |
| status_o | output | 1 | Coarse error indication toggle |

## Verification
The bench builds the block with `WIN_SHIFT`=2 and `CNT_W`=6. A period of 1 then gives a four-bit window, so window ends, back-to-back windows and mid-window period writes all occur within tens of cycles. With a 6-bit count, a period of 20 already produces more errors than the result can hold, which exercises saturation. `REG_W` stays at 8, so the coarse threshold keeps its full range, and thresholds of 0 to 7 are driven in the random phase.

// File: rtl/bit_err_pkg.sv
package bit_err_pkg;
  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_THRESH = 2'd1,
    REG_CTRL   = 2'd2
  } reg_addr_e;

  localparam int unsigned CTRL_IRQ_EN    = 0;
  localparam int unsigned CTRL_COARSE_EN = 1;
endpackage

// File: rtl/bit_err_cfg.sv
module bit_err_cfg
  import bit_err_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] period_o,
  output logic [REG_W-1:0] thresh_o,
  output logic             irq_en_o,
  output logic             coarse_en_o,
  output logic             period_wr_o,
  output logic             thresh_wr_o
);
  assign period_wr_o = wr_en_i && (wr_addr_i == REG_PERIOD);
  assign thresh_wr_o = wr_en_i && (wr_addr_i == REG_THRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o    <= '0;
      thresh_o    <= '0;
      irq_en_o    <= 1'b0;
      coarse_en_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_PERIOD: period_o <= wr_data_i;
        REG_THRESH: thresh_o <= wr_data_i;
        REG_CTRL: begin
          irq_en_o    <= wr_data_i[CTRL_IRQ_EN];
          coarse_en_o <= wr_data_i[CTRL_COARSE_EN];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bit_err_window.sv
module bit_err_window #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned WIN_SHIFT = 18,
  parameter int unsigned CNT_W     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             bit_err_i,
  input  logic [REG_W-1:0] period_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o
);
  localparam int unsigned LEN_W = REG_W + WIN_SHIFT;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LEN_W-1:0] bit_cnt_q;
  logic [LEN_W-1:0] win_last;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_sum;
  logic             take;
  logic             last;

  assign win_last = {period_i, {WIN_SHIFT{1'b0}}} - LEN_W'(1);
  assign take     = bit_valid_i && !restart_i && (period_i != '0);
  assign last     = take && (bit_cnt_q == win_last);
  assign acc_sum  = (bit_err_i && acc_q != CNT_MAX) ? acc_q + CNT_W'(1) : acc_q;
  assign done_o   = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      acc_q     <= '0;
      result_o  <= '0;
    end else if (restart_i) begin
      bit_cnt_q <= '0;
      acc_q     <= '0;
    end else if (last) begin
      bit_cnt_q <= '0;
      acc_q     <= '0;
      result_o  <= acc_sum;
    end else if (take) begin
      bit_cnt_q <= bit_cnt_q + LEN_W'(1);
      acc_q     <= acc_sum;
    end
  end
endmodule

// File: rtl/bit_err_coarse.sv
module bit_err_coarse #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic             bit_valid_i,
  input  logic             bit_err_i,
  input  logic [REG_W-1:0] thresh_i,
  output logic             status_o
);
  logic [REG_W-1:0] run_q;
  logic             hit;

  assign hit = bit_valid_i && bit_err_i && (thresh_i != '0)
               && (run_q + REG_W'(1) == thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      status_o <= 1'b0;
    end else if (!enable_i || clear_i) begin
      run_q <= '0;
    end else if (hit) begin
      run_q    <= '0;
      status_o <= !status_o;
    end else if (bit_valid_i && bit_err_i && thresh_i != '0) begin
      run_q <= run_q + REG_W'(1);
    end
  end
endmodule

// File: rtl/bit_err_monitor.sv
module bit_err_monitor #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned WIN_SHIFT = 18,
  parameter int unsigned CNT_W     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             rx_bit_i,
  input  logic             ref_bit_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] err_total_o,
  output logic             irq_no,
  output logic             status_o
);
  logic [REG_W-1:0] period;
  logic [REG_W-1:0] thresh;
  logic             irq_en;
  logic             coarse_en;
  logic             period_wr;
  logic             thresh_wr;
  logic             bit_err;
  logic             win_done;
  logic             irq_pend_q;

  assign bit_err = rx_bit_i ^ ref_bit_i;

  bit_err_cfg #(.REG_W(REG_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .thresh_o(thresh), .irq_en_o(irq_en),
    .coarse_en_o(coarse_en), .period_wr_o(period_wr), .thresh_wr_o(thresh_wr)
  );

  bit_err_window #(.REG_W(REG_W), .WIN_SHIFT(WIN_SHIFT), .CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni, .bit_valid_i, .bit_err_i(bit_err),
    .period_i(period), .restart_i(period_wr),
    .result_o(err_total_o), .done_o(win_done)
  );

  bit_err_coarse #(.REG_W(REG_W)) u_coarse (
    .clk_i, .rst_ni, .enable_i(coarse_en), .clear_i(thresh_wr),
    .bit_valid_i, .bit_err_i(bit_err), .thresh_i(thresh), .status_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 irq_pend_q <= 1'b0;
    else if (win_done && irq_en) irq_pend_q <= 1'b1;
    else if (irq_ack_i)          irq_pend_q <= 1'b0;
  end

  assign irq_no = !irq_pend_q;
endmodule

// File: rtl/bit_err_monitor_chk.sv
module bit_err_monitor_chk #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic             rx_bit_i,
  input logic             ref_bit_i,
  input logic             irq_ack_i,
  input logic [CNT_W-1:0] err_total_o,
  input logic             irq_no,
  input logic             status_o,
  input logic [REG_W-1:0] period,
  input logic             irq_en,
  input logic             coarse_en
);
  AST_RESULT_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_total_o) |-> $past(bit_valid_i)); // R5

  AST_PERIOD_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period == '0) |=> $stable(err_total_o)); // R3

  AST_IRQ_FROM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($past(bit_valid_i) && $past(irq_en))); // R7

  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !bit_valid_i) |=> irq_no); // R8

  AST_STATUS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> ($past(coarse_en) && $past(bit_valid_i)
                            && ($past(rx_bit_i) != $past(ref_bit_i)))); // R9
endmodule

bind bit_err_monitor bit_err_monitor_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/bit_err_monitor_bench.sv
module bit_err_monitor_bench;
  localparam int REG_W = 8;
  localparam int SH    = 2;
  localparam int CW    = 6;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 0, rx = 0, rf = 0, we = 0, ack = 0;
  logic [1:0] wa = '0;
  logic [REG_W-1:0] wd = '0;
  logic [CW-1:0] res;
  logic irq_n, stat;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int m_per = 0, m_thr = 0, m_bits = 0, m_acc = 0, m_res = 0, m_cc = 0;
  bit m_ien = 0, m_cen = 0, m_pend = 0, m_stat = 0;

  always #2 clk = ~clk;

  bit_err_monitor #(.REG_W(REG_W), .WIN_SHIFT(SH), .CNT_W(CW)) u_bit_err_monitor (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .rx_bit_i(rx), .ref_bit_i(rf),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .irq_ack_i(ack),
    .err_total_o(res), .irq_no(irq_n), .status_o(stat)
  );

  function automatic int sat_add(int a, int e);
    return (a + e > CMAX) ? CMAX : a + e;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " result"}, int'(res), m_res);
    chk({req, " irq_no"}, int'(irq_n), int'(!m_pend));
    chk({req, " status"}, int'(stat), int'(m_stat));
  endtask

  // one cycle: drive at negedge, update model at posedge, return at next negedge
  task automatic cyc(bit v, bit r, bit f, bit w = 0, int a = 0, int d = 0, bit k = 0);
    bit e, restart, done;
    bv = v; rx = r; rf = f; we = w; wa = 2'(a); wd = REG_W'(d); ack = k;
    @(posedge clk);
    e = r ^ f; restart = w && a == 0; done = 0;
    if (v && !restart && m_per != 0) begin
      if (m_bits == m_per * (1 << SH) - 1) begin
        m_res = sat_add(m_acc, e); m_acc = 0; m_bits = 0; done = 1;
      end else begin
        m_acc = sat_add(m_acc, e); m_bits++;
      end
    end
    if (restart) begin m_acc = 0; m_bits = 0; end
    if (done && m_ien) m_pend = 1; else if (k) m_pend = 0;
    if (!m_cen || (w && a == 1)) m_cc = 0;
    else if (v && e && m_thr != 0) begin
      if (m_cc + 1 == m_thr) begin m_stat = !m_stat; m_cc = 0; end
      else m_cc++;
    end
    if (w) begin
      if (a == 0) m_per = d & 8'hff;
      else if (a == 1) m_thr = d & 8'hff;
      else if (a == 2) begin m_ien = d[0]; m_cen = d[1]; end
    end
    @(negedge clk);
    bv = 0; we = 0; ack = 0;
  endtask

  task automatic wr(int a, int d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 result", int'(res), 0);
    chk("R11 irq_no", int'(irq_n), 1);
    chk("R11 status", int'(stat), 0);

    // R1 R2 R4 R7: four-bit window, invalid mismatches ignored
    wr(2, 1); wr(0, 1);
    cyc(1, 1, 0); cyc(0, 1, 0); cyc(1, 0, 0); cyc(0, 0, 1);
    cyc(1, 1, 0);
    chk("R2 result before window end", int'(res), 0);
    cyc(1, 0, 1);
    chk("R4 window total", int'(res), 3);
    chk("R7 irq asserted", int'(irq_n), 0);
    chk("R1 model agreement", int'(res), m_res);
    cyc(0, 0, 0);
    chk("R7 irq held", int'(irq_n), 0);

    // R5 R8: ack releases line, result kept
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R8 irq released", int'(irq_n), 1);
    chk("R5 result kept after ack", int'(res), 3);

    // R4: accumulator restarted
    repeat (4) cyc(1, 1, 1);
    chk("R4 clean window", int'(res), 0);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // R10: period write mid-window, same-cycle bit dropped
    cyc(1, 1, 0); cyc(1, 1, 0);
    cyc(1, 1, 0, 1, 0, 1);
    cyc(1, 0, 1); cyc(1, 0, 0); cyc(1, 0, 0);
    chk("R10 not yet closed", int'(res), 0);
    cyc(1, 0, 0);
    chk("R10 restarted window", int'(res), 1);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // R3: period zero disables
    wr(0, 0);
    repeat (40) cyc(1, 1, 0);
    chk("R3 result unchanged", int'(res), 1);
    chk("R3 no irq", int'(irq_n), 1);

    // R6: saturation
    wr(0, 20);
    repeat (80) cyc(1, 0, 1);
    chk("R6 saturated", int'(res), CMAX);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // R9: coarse toggling
    wr(2, 2); wr(1, 3);
    cyc(1, 1, 0); cyc(0, 1, 0); cyc(1, 1, 0);
    chk("R9 below threshold", int'(stat), 0);
    cyc(1, 1, 0);
    chk("R9 first toggle", int'(stat), 1);
    repeat (3) cyc(1, 0, 1);
    chk("R9 second toggle", int'(stat), 0);
    wr(1, 0);
    repeat (10) cyc(1, 1, 0);
    chk("R9 zero threshold", int'(stat), 0);
    chk_all("R9 model");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3)      wr(0, $urandom_range(0, 6));
      else if (r < 5) wr(1, $urandom_range(0, 7));
      else if (r < 7) wr(2, $urandom_range(0, 3));
      else cyc($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, 1'b0,
               0, 0, 0, $urandom_range(0, 9) == 0);
      chk_all("R1 R2 R4 R6 R7 R8 R9 R10 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule